// File: doc/BRIEF.md
# Channelized Stream Source Responder

This block sits on the data-source side of a time-division channelized streaming transmit link. The sink announces, one cycle at a time, which channel it wants served next: a request flag and a 6-bit channel number. A fixed number of cycles later the block answers that slot with one stream beat, `tvalid` high and `tid` equal to the announced channel. The sink therefore sets both the pace and the channel order. The source never chooses either.

For each channel the block tracks skip requests. The sink issues these as single-cycle pulses on a separate status port. Each pulse is a debt: when that channel's slot next comes up, the block sends an empty beat with the skip-response flag set, not data. A per-channel saturating credit counter holds the unpaid skips. A per-channel ready input says whether real data could be sent in the slot. When that input is low and no skip is owed, the block still answers the slot: it sends a beat with `tid` and no segment enables.

The response stage is a four-state machine. The state names the kind of beat on the outputs. `SLOT_IDLE` means no beat. `SLOT_SKIP` is a skip response. `SLOT_DATA` carries data with all segment enables set. `SLOT_EMPTY` answers the slot with no data and no skip flag. Any state moves to the next one every cycle, chosen from the slot leaving the request delay line:
- no slot leads to `SLOT_IDLE`;
- a slot whose channel has credit leads to `SLOT_SKIP`;
- a slot with no credit and ready data leads to `SLOT_DATA`;
- any other slot leads to `SLOT_EMPTY`.

Top module: `chan_src_responder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tvalid_o`, `skip_resp_o` and `seg_ena_o` are all zero.
- R2: A request sampled at a rising edge makes `tvalid_o` high for exactly one cycle, visible after the LAT-th rising edge counting the sampling edge (default LAT=4). In that cycle `tid_o` equals the requested channel. `tvalid_o` is low in every cycle that no request maps to.
- R3: A skip pulse adds one credit to channel `stat_ch_i` only when `stat_vld_i` and `stat_skip_i` are both high. With `stat_vld_i` low, or with `stat_skip_i` low, the channel's later slots are unaffected.
- R4: When a slot's channel holds credit at the decision edge, the beat has `skip_resp_o`=1 and `seg_ena_o`=0, and one credit is consumed. This applies even if the channel's ready input is high.
- R5: When a slot's channel has no credit and its `ch_ready_i` bit is high at the decision edge, the beat has `seg_ena_o` all ones and `skip_resp_o`=0.
- R6: When a slot's channel has no credit and its ready bit is low, the beat still has `tvalid_o`=1 and `tid_o` set to the channel. `seg_ena_o`=0 and `skip_resp_o`=0.
- R7: A channel's credit saturates at 15. Extra pulses beyond that are lost, so after 20 pulses exactly 15 skip beats follow before data.
- R8: A skip pulse for a channel sampled at the same edge where that channel's credit is consumed leaves the count unchanged.
- R9: Credits are kept per channel. Pulses on one channel never alter the beats of another channel. Channel numbers 40 and above never hold credit and are never ready.
- R10: Every beat with `skip_resp_o`=1 also has `tvalid_o`=1 and no segment enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 1 | Advance slot announcement |
| req_ch_i | input | 6 | Channel of the announced slot |
| stat_vld_i | input | 1 | Status fields valid |
| stat_ch_i | input | 6 | Channel the status refers to |
| stat_skip_i | input | 1 | Skip request pulse |
| ch_ready_i | input | 40 | Per-channel data-ready bits |
| tvalid_o | output | 1 | Beat valid |
| tid_o | output | 6 | Channel of the beat |
| skip_resp_o | output | 1 | Beat is a skip response |
| seg_ena_o | output | 2 | Segment enables of the beat |

## Verification
The hardest situation to reach is a skip pulse on a channel landing on the exact edge where that same channel's credit is being consumed. This needs the pulse placed LAT-1 cycles after the matching request. The bench steps one cycle at a time and advances a cycle-accurate expectation of slot decisions and credits. A directed sequence places the pulse at that offset and then checks that a further skip beat still follows. A long pseudo-random mix of requests, status pulses and ready patterns then produces many more of these collisions, along with saturation and out-of-range channels.

// File: rtl/chrsp_pkg.sv
package chrsp_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_SKIP  = 2'd1,
        SLOT_DATA  = 2'd2,
        SLOT_EMPTY = 2'd3
    } slot_e;
endpackage

// File: rtl/chrsp_req_delay.sv
module chrsp_req_delay #(
    parameter int CH_W  = 6,
    parameter int DEPTH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [CH_W-1:0] in_ch,
    output logic            out_vld,
    output logic [CH_W-1:0] out_ch
);
    logic [DEPTH-1:0] vld_q;
    logic [CH_W-1:0]  ch_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[g] <= 1'b0;
                    ch_q[g]  <= '0;
                end else begin
                    vld_q[g] <= in_vld;
                    ch_q[g]  <= in_ch;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[g] <= 1'b0;
                    ch_q[g]  <= '0;
                end else begin
                    vld_q[g] <= vld_q[g-1];
                    ch_q[g]  <= ch_q[g-1];
                end
            end
        end
    end

    assign out_vld = vld_q[DEPTH-1];
    assign out_ch  = ch_q[DEPTH-1];
endmodule

// File: rtl/chrsp_credit_cnt.sv
module chrsp_credit_cnt #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nz
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && !dec && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign nz = (cnt_q != '0);

    // R7: a full counter stays full under further pulses
    p_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && inc && !dec) |=> (cnt_q == CNT_MAX));

    // R8: pulse and consumption together leave the count alone
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(cnt_q));

    // R4: credit is only consumed when some is held
    p_credit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));
endmodule

// File: rtl/chrsp_credit_bank.sv
module chrsp_credit_bank #(
    parameter int CH_W   = 6,
    parameter int NUM_CH = 40,
    parameter int CNT_W  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc_vld,
    input  logic [CH_W-1:0] inc_ch,
    input  logic            dec_vld,
    input  logic [CH_W-1:0] dec_ch,
    input  logic [CH_W-1:0] query_ch,
    output logic            query_nz
);
    localparam logic [CH_W:0] CH_LIM = (CH_W+1)'(NUM_CH);

    logic [NUM_CH-1:0] nz_vec;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic inc_c;
        logic dec_c;
        assign inc_c = inc_vld && (inc_ch == CH_W'(c));
        assign dec_c = dec_vld && (dec_ch == CH_W'(c));
        chrsp_credit_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (inc_c),
            .dec  (dec_c),
            .nz   (nz_vec[c])
        );
    end

    assign query_nz = ({1'b0, query_ch} < CH_LIM) ? nz_vec[query_ch] : 1'b0;
endmodule

// File: rtl/chrsp_slot_fsm.sv
module chrsp_slot_fsm
    import chrsp_pkg::*;
#(
    parameter int CH_W  = 6,
    parameter int SEG_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_vld,
    input  logic [CH_W-1:0]  slot_ch,
    input  logic             credit_nz,
    input  logic             ch_rdy,
    output logic             take_credit,
    output logic             tvalid,
    output logic [CH_W-1:0]  tid,
    output logic             skip_resp,
    output logic [SEG_N-1:0] seg_ena
);
    slot_e           state_q;
    slot_e           state_d;
    logic [CH_W-1:0] tid_q;

    always_comb begin
        if (!slot_vld)      state_d = SLOT_IDLE;
        else if (credit_nz) state_d = SLOT_SKIP;
        else if (ch_rdy)    state_d = SLOT_DATA;
        else                state_d = SLOT_EMPTY;
    end

    assign take_credit = (state_d == SLOT_SKIP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            tid_q   <= '0;
        end else begin
            state_q <= state_d;
            tid_q   <= slot_vld ? slot_ch : '0;
        end
    end

    always_comb begin
        tvalid    = 1'b0;
        skip_resp = 1'b0;
        seg_ena   = '0;
        tid       = tid_q;
        unique case (state_q)
            SLOT_IDLE:  tid = '0;
            SLOT_SKIP:  begin tvalid = 1'b1; skip_resp = 1'b1; end
            SLOT_DATA:  begin tvalid = 1'b1; seg_ena = '1;     end
            SLOT_EMPTY: tvalid = 1'b1;
        endcase
    end

    // R10: a skip beat is valid and carries no segment
    p_skip_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        skip_resp |-> (tvalid && seg_ena == '0));
endmodule

// File: rtl/chan_src_responder.sv
module chan_src_responder #(
    parameter int CH_W   = 6,
    parameter int NUM_CH = 40,
    parameter int LAT    = 4,
    parameter int CNT_W  = 4,
    parameter int SEG_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld_i,
    input  logic [CH_W-1:0]   req_ch_i,
    input  logic              stat_vld_i,
    input  logic [CH_W-1:0]   stat_ch_i,
    input  logic              stat_skip_i,
    input  logic [NUM_CH-1:0] ch_ready_i,
    output logic              tvalid_o,
    output logic [CH_W-1:0]   tid_o,
    output logic              skip_resp_o,
    output logic [SEG_N-1:0]  seg_ena_o
);
    localparam int            DLY    = LAT - 1;
    localparam int            IW     = $clog2(LAT + 1) + 1;
    localparam logic [CH_W:0] CH_LIM = (CH_W+1)'(NUM_CH);

    logic            slot_vld;
    logic [CH_W-1:0] slot_ch;
    logic            credit_nz;
    logic            take_credit;
    logic            slot_rdy;
    logic            pulse;

    assign pulse = stat_vld_i && stat_skip_i;

    chrsp_req_delay #(.CH_W(CH_W), .DEPTH(DLY)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (req_vld_i),
        .in_ch  (req_ch_i),
        .out_vld(slot_vld),
        .out_ch (slot_ch)
    );

    chrsp_credit_bank #(.CH_W(CH_W), .NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_vld (pulse),
        .inc_ch  (stat_ch_i),
        .dec_vld (take_credit),
        .dec_ch  (slot_ch),
        .query_ch(slot_ch),
        .query_nz(credit_nz)
    );

    assign slot_rdy = ({1'b0, slot_ch} < CH_LIM) ? ch_ready_i[slot_ch] : 1'b0;

    chrsp_slot_fsm #(.CH_W(CH_W), .SEG_N(SEG_N)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_vld   (slot_vld),
        .slot_ch    (slot_ch),
        .credit_nz  (credit_nz),
        .ch_rdy     (slot_rdy),
        .take_credit(take_credit),
        .tvalid     (tvalid_o),
        .tid        (tid_o),
        .skip_resp  (skip_resp_o),
        .seg_ena    (seg_ena_o)
    );

    // Requests announced but not yet answered; used only by the checks below.
    logic [IW-1:0] inflight_q;
    always_ff @(posedge clk) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_q + IW'(req_vld_i) - IW'(tvalid_o);
    end

    // R2: no beat without an outstanding request
    p_no_orphan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tvalid_o |-> (inflight_q != '0));

    // R2: requests never pile up beyond the fixed latency
    p_inflight_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= IW'(LAT));
endmodule

// File: tb/chan_src_responder_test.sv
`timescale 1ns/1ps
module chan_src_responder_test;
    localparam int LAT = 4;
    localparam int NCH = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_vld_i = 1'b0;
    logic [5:0]      req_ch_i = '0;
    logic            stat_vld_i = 1'b0;
    logic [5:0]      stat_ch_i = '0;
    logic            stat_skip_i = 1'b0;
    logic [NCH-1:0]  ch_ready_i = '0;
    logic            tvalid_o;
    logic [5:0]      tid_o;
    logic            skip_resp_o;
    logic [1:0]      seg_ena_o;

    always #4 clk = ~clk;

    chan_src_responder uut (
        .clk(clk), .rst_n(rst_n),
        .req_vld_i(req_vld_i), .req_ch_i(req_ch_i),
        .stat_vld_i(stat_vld_i), .stat_ch_i(stat_ch_i), .stat_skip_i(stat_skip_i),
        .ch_ready_i(ch_ready_i),
        .tvalid_o(tvalid_o), .tid_o(tid_o), .skip_resp_o(skip_resp_o), .seg_ena_o(seg_ena_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // expectation model state
    int   cred [NCH];
    bit   hv [LAT];
    int   hc [LAT];
    bit   e_v = 0, e_sk = 0;
    int   e_id = 0;
    logic [1:0] e_en = '0;
    string tag = "";
    logic [31:0] lf = 32'h1ACE_B00C;

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13; y ^= y >> 17; y ^= y << 5;
        return y;
    endfunction

    task automatic check_now();
        string t;
        bit ok;
        t = tag;
        if (t == "") t = !e_v ? "R2" : e_sk ? "R4" : (e_en != 0) ? "R5" : "R6";
        ok = (tvalid_o == e_v) && (skip_resp_o == e_sk) && (seg_ena_o == e_en) &&
             (!e_v || tid_o == 6'(e_id));
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got v=%0b id=%0d sk=%0b en=%b expected v=%0b id=%0d sk=%0b en=%b",
                     t, tvalid_o, tid_o, skip_resp_o, seg_ena_o, e_v, e_id, e_sk, e_en);
        end
    endtask

    // one cycle: check outputs, apply inputs, advance expectation
    task automatic tick(input bit rv, input int rc, input bit sv, input int sc,
                        input bit sk, input logic [NCH-1:0] rdy);
        int ch;
        bit dec;
        bit inc;
        @(negedge clk);
        check_now();
        req_vld_i = rv; req_ch_i = 6'(rc);
        stat_vld_i = sv; stat_ch_i = 6'(sc); stat_skip_i = sk;
        ch_ready_i = rdy;
        for (int i = LAT - 1; i > 0; i--) begin hv[i] = hv[i-1]; hc[i] = hc[i-1]; end
        hv[0] = rv; hc[0] = rc;
        dec = 0;
        ch = hc[LAT-1];
        e_sk = 0; e_en = '0; e_v = hv[LAT-1]; e_id = ch;
        if (hv[LAT-1]) begin
            if (ch < NCH && cred[ch] > 0) begin e_sk = 1; dec = 1; end
            else if (ch < NCH && rdy[ch]) e_en = 2'b11;
        end
        inc = sv && sk && sc < NCH;
        if (dec && inc && sc == ch) begin
            // R8: count unchanged
        end else begin
            if (dec) cred[ch]--;
            if (inc && cred[sc] < 15) cred[sc]++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NCH; i++) cred[i] = 0;
        for (int i = 0; i < LAT; i++) begin hv[i] = 0; hc[i] = 0; end
        // R1: reset state
        repeat (3) @(negedge clk);
        n_chk++;
        if (tvalid_o || skip_resp_o || seg_ena_o != 0) begin
            n_bad++;
            $display("FAIL R1: got v=%0b sk=%0b en=%b expected 0 0 00", tvalid_o, skip_resp_o, seg_ena_o);
        end
        rst_n = 1'b1;
        tag = "R1"; idle(1); tag = "";

        // R2 R5 R6: sweep every channel with a mixed ready pattern
        begin
            logic [NCH-1:0] rp;
            for (int c = 0; c < NCH; c++) rp[c] = (c % 3) != 0;
            for (int c = 0; c < NCH; c++) tick(1, c, 0, 0, 0, rp);
            idle(LAT);
            for (int c = 0; c < NCH; c += 2) begin tick(1, c, 0, 0, 0, ~rp); idle(1); end
            idle(LAT);
        end

        // R3: pulses without status valid, or without the skip flag, are ignored
        tag = "R3";
        for (int c = 0; c < 10; c++) tick(0, 0, 0, c, 1, '1);
        for (int c = 0; c < 10; c++) tick(0, 0, 1, c, 0, '1);
        for (int c = 0; c < 10; c++) tick(1, c, 0, 0, 0, '1);
        idle(LAT);

        // R9: per-channel credits, channel c gets c%3 pulses
        tag = "R9";
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < c % 3; k++) tick(0, 0, 1, c, 1, '1);
        idle(2);
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < NCH; c++) tick(1, c, 0, 0, 0, '1);
        tick(1, 50, 1, 50, 1, '1);
        tick(1, 50, 0, 0, 0, '1);
        idle(LAT);

        // R7: saturation at 15
        tag = "R7";
        for (int k = 0; k < 20; k++) tick(0, 0, 1, 7, 1, '1);
        idle(2);
        for (int k = 0; k < 17; k++) tick(1, 7, 0, 0, 0, '1);
        idle(LAT);

        // R8: pulse lands on the consuming edge of the same channel
        tag = "R8";
        tick(0, 0, 1, 9, 1, '1);
        idle(2);
        tick(1, 9, 0, 0, 0, '1);
        idle(LAT - 2);
        tick(0, 0, 1, 9, 1, '1);
        idle(2);
        tick(1, 9, 0, 0, 0, '1);
        tick(1, 9, 0, 0, 0, '1);
        idle(LAT);

        // mixed pseudo-random traffic
        tag = "";
        for (int i = 0; i < 600; i++) begin
            logic [NCH-1:0] rr;
            lf = nxt(lf);
            rr = {lf[7:0], lf} ^ {lf, lf[7:0]};
            tick(lf[0] | lf[1], int'(lf[8:3]) % 44, lf[12], int'(lf[18:13]) % 12,
                 lf[19] | lf[20], rr);
        end
        idle(LAT + 1);
        finish_run();
    end
endmodule